// File: doc/BRIEF.md
# Transmit Checksum Inserter

This unit sits in a transmit path ahead of the MAC. Before each frame, a control payload of five 32-bit words arrives on a side stream. It gives an enable flag, the byte offset where summing starts, the byte offset where the result goes, and a 16-bit seed. The frame then arrives as a byte-wide stream and is stored in an internal buffer. While it is stored, the unit adds up the frame as 16-bit big-endian words, starting at the start offset and running to the last byte. It then folds and inverts the sum, writes it into the buffered frame and sends the patched frame out on a byte-wide stream.

The unit holds one frame at a time, so the input stream stalls from the last input byte until the last output byte has been accepted. Three configuration levels control whether a finished frame is sent or dropped: transmit enable, jumbo enable and VLAN enable. Each sent frame raises a one-cycle done pulse and adds its length to a 64-bit byte counter. Bytes beyond the buffer depth are discarded and leave the stored length at the depth.

Top module: `tx_csum_insert`

## Requirements
- R1: A control payload takes effect only if its fifth word carries `ctl_tlast`. The fields are: word 0 bit 0 is the insert enable, word 1 bits 31:16 are the start offset, word 1 bits 15:0 are the insert offset, and word 2 bits 15:0 are the seed. All other bits are ignored. After a valid payload, `s_tready` rises and one frame is accepted.
- R2: If `ctl_tlast` arrives on any word other than the fifth, the payload is discarded. `ctl_err` pulses for one cycle, in the cycle after that word's handshake, and the unit keeps waiting for control (`ctl_tready` high, `s_tready` low).
- R3: The checksum is built as follows. Start from the seed. Add the bytes from the start offset to the end of the frame as big-endian 16-bit words, counting pairs from the start offset; an odd final byte is the high byte of a word whose low byte is zero. Fold the upper 16 bits into the lower 16 bits until no carry remains, then invert. If the start offset is at or beyond the frame end, only the seed is summed.
- R4: When insertion is enabled, the high checksum byte replaces the byte at the insert offset and the low byte replaces the byte at the insert offset plus one. Either position at or beyond the frame length is left out, and the frame length never changes.
- R5: With insert enable clear, the frame leaves exactly as it entered.
- R6: With `cfg_tx_en` low at the frame's last byte, the frame is dropped: no output, no done pulse, no count.
- R7: With `cfg_jumbo` and `cfg_vlan` both low, frames of 1519 to 1522 bytes are dropped. Frames of 1518 or 1523 bytes are sent. Setting either `cfg_jumbo` or `cfg_vlan` lets 1519 to 1522 bytes through.
- R8: Each sent frame gives exactly one `tx_done` pulse, in the cycle after its last output handshake, and `tx_bytes` grows by the frame length at the same time.
- R9: `s_tready` stays low while the output is busy. The output frame has the input length, with `m_tlast` on its last byte only.
- R10: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` and `m_tdata` hold.
- R11: After reset: `m_tvalid`, `s_tready`, `tx_done` and `ctl_err` are low, `ctl_tready` is high and `tx_bytes` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_tx_en | input | 1 | Transmit enable, sampled at frame end |
| cfg_jumbo | input | 1 | Jumbo enable, sampled at frame end |
| cfg_vlan | input | 1 | VLAN-size enable, sampled at frame end |
| ctl_tdata | input | 32 | Control word |
| ctl_tvalid | input | 1 | Control word valid |
| ctl_tlast | input | 1 | Last word of control payload |
| ctl_tready | output | 1 | Control word accepted |
| s_tdata | input | 8 | Input frame byte |
| s_tvalid | input | 1 | Input byte valid |
| s_tlast | input | 1 | Last input byte of frame |
| s_tready | output | 1 | Input byte accepted |
| m_tdata | output | 8 | Output frame byte |
| m_tvalid | output | 1 | Output byte valid |
| m_tlast | output | 1 | Last output byte of frame |
| m_tready | input | 1 | Output byte accepted downstream |
| ctl_err | output | 1 | Pulse: control payload of wrong length |
| tx_done | output | 1 | Pulse: frame fully sent |
| tx_bytes | output | 64 | Running count of sent bytes |

## Verification
The hardest condition to reach is the size-drop window, because it only opens for frames of 1519 to 1522 bytes. The bench therefore drives full-length frames on both sides of the window under each setting of jumbo and VLAN enable. The fold loop only runs several times when the sum carries heavily, so one long frame of all-ones bytes with an all-ones seed is used to force repeated folding. Insert offsets that fall on or just past the last byte only occur when offsets are swept against the frame length. The bench sweeps every start offset for each short length, with the insert offset wrapping past the frame end, and applies irregular output backpressure on part of the sweep.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  localparam int CTL_WORDS = 5;

  typedef enum logic [2:0] {
    ST_CTRL, ST_RECV, ST_FOLD, ST_PHI, ST_PLO, ST_SEND
  } tcs_state_t;

  typedef struct packed {
    logic        en;
    logic [15:0] start;
    logic [15:0] ins;
    logic [15:0] seed;
  } tcs_ctl_t;
endpackage

// File: rtl/tcs_ctl_parse.sv
module tcs_ctl_parse
  import tcs_pkg::*;
#(
  parameter int CW = 32,
  parameter int NW = CTL_WORDS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] wdata,
  input  logic          wfire,
  input  logic          wlast,
  output tcs_ctl_t      ctl,
  output logic          ok,
  output logic          bad
);
  localparam int CNTW = $clog2(NW + 1);

  logic [CNTW-1:0] cnt;
  logic            unused_bits;

  assign unused_bits = ^{wdata[CW-1:1]};
  assign ok  = wfire && wlast && (cnt == CNTW'(NW - 1));
  assign bad = wfire && wlast && (cnt != CNTW'(NW - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ctl <= '0;
    end else if (wfire) begin
      if (wlast) cnt <= '0;
      else if (cnt != CNTW'(NW)) cnt <= cnt + CNTW'(1);
      case (cnt)
        CNTW'(0): ctl.en <= wdata[0];
        CNTW'(1): begin
          ctl.start <= wdata[31:16];
          ctl.ins   <= wdata[15:0];
        end
        CNTW'(2): ctl.seed <= wdata[15:0];
        default: ;
      endcase
    end
  end

  assert property (@(posedge clk) disable iff (rst)
    wfire && wlast |=> cnt == '0) else $error("assert_cnt_restart_R2");
endmodule

// File: rtl/tcs_sum.sv
module tcs_sum #(
  parameter int SW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [15:0]   seed,
  input  logic          add,
  input  logic          hi,
  input  logic [7:0]    din,
  input  logic          fold,
  output logic [SW-1:0] sum,
  output logic          folded
);
  logic [SW-1:0] addend;

  assign addend = hi ? SW'({din, 8'h00}) : SW'(din);
  assign folded = (sum[SW-1:16] == '0);

  always_ff @(posedge clk) begin
    if (rst) sum <= '0;
    else if (load) sum <= SW'(seed);
    else if (add) sum <= sum + addend;
    else if (fold) sum <= SW'(sum[15:0]) + SW'(sum[SW-1:16]);
  end

  assert_fold_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
    fold && !folded && !load && !add |=> sum < $past(sum));
endmodule

// File: rtl/tcs_ram.sv
module tcs_ram #(
  parameter int DEPTH = 2048,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tx_csum_insert.sv
module tx_csum_insert
  import tcs_pkg::*;
#(
  parameter int DEPTH    = 2048,
  parameter int CW       = 32,
  parameter int MAX_STD  = 1518,
  parameter int MAX_VLAN = 1522
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_tx_en,
  input  logic          cfg_jumbo,
  input  logic          cfg_vlan,
  input  logic [CW-1:0] ctl_tdata,
  input  logic          ctl_tvalid,
  input  logic          ctl_tlast,
  output logic          ctl_tready,
  input  logic [7:0]    s_tdata,
  input  logic          s_tvalid,
  input  logic          s_tlast,
  output logic          s_tready,
  output logic [7:0]    m_tdata,
  output logic          m_tvalid,
  output logic          m_tlast,
  input  logic          m_tready,
  output logic          ctl_err,
  output logic          tx_done,
  output logic [63:0]   tx_bytes
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int SW = 32;

  tcs_state_t    state;
  tcs_ctl_t      ctl;
  logic          par_ok, par_bad;
  logic [LW-1:0] wr_cnt, len, new_len;
  logic [AW-1:0] rd_idx, raddr, waddr;
  logic [7:0]    wdata, rdata;
  logic          we, out_valid, room, in_fire, past_start, drop_now;
  logic          hi_ok, lo_ok, m_fire, last_out, folded;
  logic [SW-1:0] sum;
  logic [15:0]   csum;

  assign ctl_tready = (state == ST_CTRL);
  assign s_tready   = (state == ST_RECV);

  tcs_ctl_parse #(.CW(CW), .NW(CTL_WORDS)) u_parse (
    .clk(clk), .rst(rst), .wdata(ctl_tdata),
    .wfire(ctl_tvalid && ctl_tready), .wlast(ctl_tlast),
    .ctl(ctl), .ok(par_ok), .bad(par_bad)
  );

  assign in_fire    = s_tvalid && s_tready;
  assign room       = (wr_cnt < LW'(DEPTH));
  assign past_start = (32'(wr_cnt) >= 32'(ctl.start));
  assign new_len    = room ? wr_cnt + LW'(1) : wr_cnt;
  assign drop_now   = !cfg_tx_en ||
                      (!cfg_jumbo && !cfg_vlan &&
                       32'(new_len) > MAX_STD && 32'(new_len) <= MAX_VLAN);

  tcs_sum #(.SW(SW)) u_sum (
    .clk(clk), .rst(rst), .load(par_ok), .seed(ctl.seed),
    .add(in_fire && room && past_start), .hi(wr_cnt[0] == ctl.start[0]),
    .din(s_tdata), .fold(state == ST_FOLD && !folded),
    .sum(sum), .folded(folded)
  );

  assign csum  = ~sum[15:0];
  assign hi_ok = ctl.en && (32'(ctl.ins) < 32'(len));
  assign lo_ok = ctl.en && (32'(ctl.ins) + 1 < 32'(len));

  always_comb begin
    we    = 1'b0;
    waddr = wr_cnt[AW-1:0];
    wdata = s_tdata;
    case (state)
      ST_RECV: we = in_fire && room;
      ST_PHI: begin
        we    = hi_ok;
        waddr = ctl.ins[AW-1:0];
        wdata = csum[15:8];
      end
      ST_PLO: begin
        we    = lo_ok;
        waddr = ctl.ins[AW-1:0] + AW'(1);
        wdata = csum[7:0];
      end
      default: ;
    endcase
  end

  assign m_fire   = out_valid && m_tready;
  assign last_out = (32'(rd_idx) + 1 == 32'(len));
  assign raddr    = (state == ST_SEND && m_fire && !last_out) ? rd_idx + AW'(1) : rd_idx;

  tcs_ram #(.DEPTH(DEPTH), .W(8)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(rdata)
  );

  assign m_tdata  = rdata;
  assign m_tvalid = out_valid;
  assign m_tlast  = out_valid && last_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CTRL;
      wr_cnt    <= '0;
      len       <= '0;
      rd_idx    <= '0;
      out_valid <= 1'b0;
      tx_done   <= 1'b0;
      ctl_err   <= 1'b0;
      tx_bytes  <= '0;
    end else begin
      tx_done <= 1'b0;
      ctl_err <= par_bad;
      case (state)
        ST_CTRL: if (par_ok) begin
          state  <= ST_RECV;
          wr_cnt <= '0;
        end
        ST_RECV: if (in_fire) begin
          wr_cnt <= new_len;
          if (s_tlast) begin
            len   <= new_len;
            state <= drop_now ? ST_CTRL : ST_FOLD;
          end
        end
        ST_FOLD: if (folded) state <= ST_PHI;
        ST_PHI:  state <= ST_PLO;
        ST_PLO: begin
          state     <= ST_SEND;
          rd_idx    <= '0;
          out_valid <= 1'b0;
        end
        ST_SEND: begin
          if (!out_valid) out_valid <= 1'b1;
          else if (m_fire) begin
            if (last_out) begin
              out_valid <= 1'b0;
              state     <= ST_CTRL;
              tx_done   <= 1'b1;
              tx_bytes  <= tx_bytes + 64'(len);
            end else begin
              rd_idx <= rd_idx + AW'(1);
            end
          end
        end
        default: state <= ST_CTRL;
      endcase
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata));
  assert_stall_R9: assert property (@(posedge clk) disable iff (rst)
    m_tvalid |-> !s_tready);
  assert_frame_end_R9: assert property (@(posedge clk) disable iff (rst)
    m_tvalid && m_tlast && m_tready |=> !m_tvalid && tx_done);
  assert_count_R8: assert property (@(posedge clk) disable iff (rst)
    tx_bytes != $past(tx_bytes) |-> tx_done);
  assert_err_wait_R2: assert property (@(posedge clk) disable iff (rst)
    ctl_err |-> ctl_tready && !s_tready);
endmodule

// File: tb/tb_tx_csum_insert.sv
module tb_tx_csum_insert;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cfg_tx_en = 1'b1, cfg_jumbo = 1'b0, cfg_vlan = 1'b0;
  logic [31:0] ctl_tdata = '0;
  logic        ctl_tvalid = 1'b0, ctl_tlast = 1'b0, ctl_tready;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
  logic [7:0]  m_tdata;
  logic        m_tvalid, m_tlast, m_tready;
  logic        ctl_err, tx_done;
  logic [63:0] tx_bytes;

  tx_csum_insert dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  int out_n = 0, done_cnt = 0, err_cnt = 0, stall_bad = 0, cyc = 0;
  bit bp_mode = 1'b0;
  logic [7:0] out_mem [0:4095];
  bit         out_last [0:4095];
  logic [7:0] fb [0:2047];
  logic [63:0] exp_bytes = 0;

  initial m_tready = 1'b1;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    m_tready = bp_mode ? ((cyc % 3) != 1) : 1'b1;
    if (!rst) begin
      if (m_tvalid && m_tready) begin
        out_mem[out_n % 4096]  = m_tdata;
        out_last[out_n % 4096] = m_tlast;
        out_n = out_n + 1;
      end
      if (tx_done) done_cnt = done_cnt + 1;
      if (ctl_err) err_cnt = err_cnt + 1;
      if (m_tvalid && s_tready) stall_bad = stall_bad + 1;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_ctrl(input int nw, input bit en, input int start, input int ins, input int seed);
    for (int w = 0; w < nw; w++) begin
      case (w)
        0: ctl_tdata = {31'h12345, en};
        1: ctl_tdata = {start[15:0], ins[15:0]};
        2: ctl_tdata = {16'hBEEF, seed[15:0]};
        default: ctl_tdata = 32'hC0DE0000 + w;
      endcase
      ctl_tlast  = (w == nw - 1);
      ctl_tvalid = 1'b1;
      while (!ctl_tready) @(negedge clk);
      @(negedge clk);
    end
    ctl_tvalid = 1'b0;
    ctl_tlast  = 1'b0;
  endtask

  task automatic push_frame(input int len);
    for (int i = 0; i < len; i++) begin
      s_tdata  = fb[i];
      s_tlast  = (i == len - 1);
      s_tvalid = 1'b1;
      while (!s_tready) @(negedge clk);
      @(negedge clk);
    end
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  function automatic logic [15:0] model_csum(input int len, input int start, input int seed);
    longint s = seed;
    for (int i = start; i < len; i++)
      s += (((i - start) % 2) == 0) ? (longint'(fb[i]) << 8) : longint'(fb[i]);
    while ((s >> 16) != 0) s = (s & 64'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  // pat 0: arithmetic bytes, pat 1: all 0xFF
  task automatic run_frame(input int len, input bit en, input int start, input int ins,
                           input int seed, input int pat, input bit sent, input string req);
    int base, d0, bad, first_i, lastbad;
    logic [15:0] c;
    logic [7:0] e;
    for (int i = 0; i < len; i++)
      fb[i] = (pat == 1) ? 8'hFF : 8'((i * 73 + len * 11 + start) & 255);
    c = model_csum(len, start, seed);
    send_ctrl(5, en, start, ins, seed);
    base = out_n;
    d0 = done_cnt;
    push_frame(len);
    if (sent) begin
      while (out_n - base < len) @(negedge clk);
      repeat (3) @(negedge clk);
      bad = 0; first_i = -1; lastbad = 0;
      for (int i = 0; i < len; i++) begin
        e = fb[i];
        if (en && i == ins) e = c[15:8];
        if (en && i == ins + 1) e = c[7:0];
        if (out_mem[(base + i) % 4096] !== e) begin
          if (first_i < 0) first_i = i;
          bad++;
        end
        if (out_last[(base + i) % 4096] != (i == len - 1)) lastbad++;
      end
      if (first_i >= 0)
        check(0, {req, " data byte"}, out_mem[(base + first_i) % 4096],
              (en && first_i == ins) ? c[15:8] : (en && first_i == ins + 1) ? c[7:0] : fb[first_i]);
      else check(1, req, 0, 0);
      check(lastbad == 0 && out_n - base == len, "R9 length/tlast", out_n - base, len);
      exp_bytes += len;
      check(done_cnt == d0 + 1, "R8 done pulse", done_cnt - d0, 1);
      check(tx_bytes == exp_bytes, "R8 byte count", tx_bytes, exp_bytes);
    end else begin
      repeat (12) @(negedge clk);
      check(out_n == base && done_cnt == d0, {req, " dropped output"}, out_n - base, 0);
      check(tx_bytes == exp_bytes, {req, " dropped count"}, tx_bytes, exp_bytes);
      check(ctl_tready == 1'b1, {req, " back to control"}, ctl_tready, 1);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!m_tvalid && !s_tready && ctl_tready, "R11 handshakes", {m_tvalid, s_tready, ctl_tready}, 3'b001);
    check(tx_bytes == 0 && !tx_done && !ctl_err, "R11 status", tx_bytes, 0);

    // R3 R4 R1 sweep: every start per length, insert offset wrapping past the end
    for (int len = 1; len <= 16; len++)
      for (int st = 0; st <= len; st++) begin
        bp_mode = st[0];
        run_frame(len, 1'b1, st, (st * 3 + len) % (len + 2),
                  (len * 4099 + st * 257) & 16'hFFFF, 0, 1'b1, "R1/R3/R4 sweep");
      end
    bp_mode = 1'b0;

    // R5 passthrough with insert disabled
    for (int len = 2; len <= 9; len++)
      run_frame(len, 1'b0, 0, 0, 16'h1234, 0, 1'b1, "R5 passthrough");

    // R3 heavy carry fold, all-ones seed
    bp_mode = 1'b1;
    run_frame(1518, 1'b1, 0, 20, 16'hFFFF, 1, 1'b1, "R3 carry fold");
    bp_mode = 1'b0;

    // R2 wrong payload lengths
    e0 = err_cnt;
    send_ctrl(4, 1'b1, 0, 0, 0);
    repeat (2) @(negedge clk);
    check(err_cnt == e0 + 1, "R2 short payload err", err_cnt - e0, 1);
    check(!s_tready && ctl_tready, "R2 still waiting", s_tready, 0);
    send_ctrl(6, 1'b1, 0, 0, 0);
    repeat (2) @(negedge clk);
    check(err_cnt == e0 + 2, "R2 long payload err", err_cnt - e0, 2);
    check(!s_tready && ctl_tready, "R2 still waiting long", s_tready, 0);
    run_frame(12, 1'b1, 2, 4, 16'h00F0, 0, 1'b1, "R1 after error");

    // R6 transmit disabled
    cfg_tx_en = 1'b0;
    run_frame(10, 1'b1, 0, 2, 0, 0, 1'b0, "R6 tx disabled");
    cfg_tx_en = 1'b1;

    // R7 size window
    run_frame(1519, 1'b1, 14, 24, 16'h0101, 0, 1'b0, "R7 1519 drop");
    run_frame(1522, 1'b1, 14, 24, 16'h0101, 0, 1'b0, "R7 1522 drop");
    run_frame(1523, 1'b1, 14, 1521, 16'h0101, 0, 1'b1, "R7 1523 sent");
    cfg_vlan = 1'b1;
    run_frame(1520, 1'b1, 14, 1519, 16'h7777, 0, 1'b1, "R7 vlan 1520 sent");
    cfg_vlan = 1'b0;
    cfg_jumbo = 1'b1;
    run_frame(1521, 1'b1, 1, 100, 16'h8001, 0, 1'b1, "R7 jumbo 1521 sent");
    cfg_jumbo = 1'b0;

    check(stall_bad == 0, "R9 input stalled while sending", stall_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule